// File: doc/BRIEF.md
# Carry-Scan Testable Ripple Adder

This block is a ripple-carry adder whose internal carries can be reached from test pins. In normal operation it adds two operands and a carry-in. The sum and the final carry-out appear combinationally, with no register in the path.

For production test, a test-mode select breaks the carry chain at every stage boundary above stage 0. While test mode is selected, each of those stages takes its carry input from one bit of a serially loaded control register instead of from the stage below. A second register captures every stage's carry output in one clock. It then shifts those values out one per clock on a serial pin.

Every stage is then controllable and observable on its own. All stages can be exercised in parallel, so eight operand/carry combinations test every full adder exhaustively. The sum bits need no extra capture logic because they are already outputs.

Top module: `carry_scan_adder`

## Requirements
- R1: With `test_mode` low, `{cout, sum}` equals `a + b + cin` for any operands, and the registers have no effect on it.
- R2: With `test_mode` high, stage 0 adds `a[0]`, `b[0]` and `cin`. Every stage i from 1 to WIDTH-1 takes its carry input from control bit i instead of from stage i-1, so `sum[i] = a[i] ^ b[i] ^ ctrl[i]`.
- R3: The control register shifts only on clocks where `ctl_shift_en` is high. Control bit 1 takes `scan_in`, and bit i takes the old bit i-1. The first of WIDTH-1 shifted bits therefore ends in bit WIDTH-1. With `ctl_shift_en` low, the register holds and its outputs stay stable.
- R4: On a clock with `cap_load` high, capture bit i takes the carry output of stage i-1, for every i from 1 to WIDTH-1, all at once.
- R5: `scan_out` always shows capture bit WIDTH-1. On a clock with `cap_shift` high and `cap_load` low, every capture bit moves up one place and bit 1 fills with 0. After a load, the carries leave in the order stage WIDTH-2 down to stage 0. With neither enable high, the capture register holds.
- R6: When `cap_load` and `cap_shift` are high in the same clock, the load takes effect and the shift is ignored.
- R7: An active-low `rst_n` clears both registers asynchronously. After reset, `scan_out` is 0 and in test mode every stage above 0 sees a carry input of 0.
- R8: `cout` is the carry output of the top stage in both modes. In test mode it equals the majority of `a[WIDTH-1]`, `b[WIDTH-1]` and control bit WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the two test registers |
| rst_n | input | 1 | Asynchronous active-low reset of both registers |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into stage 0 |
| sum | output | WIDTH | Sum bits, one per stage |
| cout | output | 1 | Carry out of the top stage |
| test_mode | input | 1 | Static select: high breaks the carry chain onto the control register |
| scan_in | input | 1 | Serial input of the control register |
| ctl_shift_en | input | 1 | Shift enable of the control register |
| cap_load | input | 1 | Parallel capture of the stage carries |
| cap_shift | input | 1 | Shift enable of the capture register |
| scan_out | output | 1 | Serial output, capture bit WIDTH-1 |

## Verification
The assertions assume that `test_mode` is a static select. They also assume that operands and enables settle between clock edges. The combinational sum checks therefore apply only outside reset, with inputs that are already stable.

The bench drives every input half a period after the rising edge. It samples half a period after each edge. It holds `test_mode` fixed across each capture and shift-out sequence. It asserts `cap_load` and `cap_shift` together only in the one scenario that checks load priority.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int unsigned ADD_W = 32;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/cst_fa_stage.sv
module cst_fa_stage (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  import cst_pkg::*;
  assign s  = a ^ b ^ ci;
  assign co = maj3(a, b, ci);
endmodule

// File: rtl/cst_carry_path.sv
module cst_carry_path #(
  parameter int unsigned WIDTH = cst_pkg::ADD_W
) (
  input  logic             test_mode,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic [WIDTH-2:0] ctrl,   // ctrl[k] feeds stage k+1 in test mode
  output logic [WIDTH-1:0] sum,
  output logic [WIDTH-1:0] co      // carry output of each stage
);
  logic [WIDTH-1:0] ci;

  assign ci[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i > 0) begin : g_mux
      assign ci[i] = test_mode ? ctrl[i-1] : co[i-1];
    end
    cst_fa_stage u_fa (
      .a (a[i]),
      .b (b[i]),
      .ci(ci[i]),
      .s (sum[i]),
      .co(co[i])
    );
  end

  always_comb begin
    if (test_mode) begin
      p_stage0_direct_r2: assert (sum[0] == (a[0] ^ b[0] ^ cin));
    end
  end
endmodule

// File: rtl/cst_ctrl_chain.sv
module cst_ctrl_chain #(
  parameter int unsigned LEN = cst_pkg::ADD_W - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           serial_in,
  output logic [LEN-1:0] q          // q[0] nearest serial_in
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[LEN-2:0], serial_in};
  end

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
  p_entry_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[0] == $past(serial_in));
  p_move_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> q[LEN-1:1] == $past(q[LEN-2:0]));
endmodule

// File: rtl/cst_capture_chain.sv
module cst_capture_chain #(
  parameter int unsigned LEN = cst_pkg::ADD_W - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic [LEN-1:0] par_in,
  output logic           serial_out
);
  logic [LEN-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= par_in;
    else if (shift) q <= {q[LEN-2:0], 1'b0};
  end

  assign serial_out = q[LEN-1];

  p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(par_in));
  p_shift_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift) |=> q[0] == 1'b0 && serial_out == $past(q[LEN-2]));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(q));
endmodule

// File: rtl/carry_scan_adder.sv
module carry_scan_adder #(
  parameter int unsigned WIDTH = cst_pkg::ADD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  input  logic             test_mode,
  input  logic             scan_in,
  input  logic             ctl_shift_en,
  input  logic             cap_load,
  input  logic             cap_shift,
  output logic             scan_out
);
  localparam int unsigned NLINK = WIDTH - 1;

  logic [NLINK-1:0] ctrl;
  logic [WIDTH-1:0] stage_co;

  cst_ctrl_chain #(.LEN(NLINK)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (ctl_shift_en),
    .serial_in(scan_in),
    .q        (ctrl)
  );

  cst_carry_path #(.WIDTH(WIDTH)) u_path (
    .test_mode(test_mode),
    .a        (a),
    .b        (b),
    .cin      (cin),
    .ctrl     (ctrl),
    .sum      (sum),
    .co       (stage_co)
  );

  cst_capture_chain #(.LEN(NLINK)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cap_load),
    .shift     (cap_shift),
    .par_in    (stage_co[WIDTH-2:0]),
    .serial_out(scan_out)
  );

  assign cout = stage_co[WIDTH-1];

  always_comb begin
    if (rst_n && !test_mode) begin
      p_normal_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
    end
  end

  p_capture_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_load |=> scan_out == $past(stage_co[WIDTH-2]));
endmodule

// File: tb/carry_scan_adder_tb.sv
`timescale 1ns/1ps
module carry_scan_adder_tb;
  localparam int W = 32;
  localparam int L = W - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic cin = 1'b0, test_mode = 1'b0, scan_in = 1'b0;
  logic ctl_shift_en = 1'b0, cap_load = 1'b0, cap_shift = 1'b0;
  logic [W-1:0] sum;
  logic cout, scan_out;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  carry_scan_adder #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout),
    .test_mode(test_mode), .scan_in(scan_in), .ctl_shift_en(ctl_shift_en),
    .cap_load(cap_load), .cap_shift(cap_shift), .scan_out(scan_out)
  );

  function automatic logic mj(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // p[k] is the carry for stage k+1; shifted highest first (R3)
  task automatic load_ctrl(input logic [L-1:0] p);
    for (int j = L - 1; j >= 0; j--) begin
      @(negedge clk);
      scan_in = p[j];
      ctl_shift_en = 1'b1;
    end
    @(negedge clk);
    ctl_shift_en = 1'b0;
    scan_in = 1'b0;
  endtask

  function automatic logic [W-1:0] exp_test_sum(input logic [W-1:0] x, input logic [W-1:0] y,
                                                 input logic c0, input logic [L-1:0] p);
    logic [W-1:0] r;
    r[0] = x[0] ^ y[0] ^ c0;
    for (int i = 1; i < W; i++) r[i] = x[i] ^ y[i] ^ p[i-1];
    return r;
  endfunction

  function automatic logic [W-1:0] exp_test_co(input logic [W-1:0] x, input logic [W-1:0] y,
                                                input logic c0, input logic [L-1:0] p);
    logic [W-1:0] r;
    r[0] = mj(x[0], y[0], c0);
    for (int i = 1; i < W; i++) r[i] = mj(x[i], y[i], p[i-1]);
    return r;
  endfunction

  // capture, then shift out stages W-2 down to 0 (R4, R5)
  task automatic capture_and_check(input logic [W-1:0] eco, input string tag);
    @(negedge clk);
    cap_load = 1'b1;
    @(negedge clk);
    cap_load = 1'b0;
    for (int j = W - 2; j >= 0; j--) begin
      chk(scan_out === eco[j], tag, {63'd0, scan_out}, {63'd0, eco[j]});
      cap_shift = 1'b1;
      @(negedge clk);
    end
    cap_shift = 1'b0;
    chk(scan_out === 1'b0, "R5 zero fill after drain", {63'd0, scan_out}, 64'd0);
  endtask

  task automatic t_reset();
    test_mode = 1'b1; a = '1; b = '0; cin = 1'b0;
    @(negedge clk);
    chk(scan_out === 1'b0, "R7 scan_out after reset", {63'd0, scan_out}, 64'd0);
    chk(sum === '1, "R7 control bits zero after reset", {32'd0, sum}, {32'd0, {W{1'b1}}});
    chk(cout === 1'b0, "R8 cout with zero control", {63'd0, cout}, 64'd0);
  endtask

  task automatic t_exhaustive();
    for (int k = 0; k < 8; k++) begin
      logic xa, xb, xc;
      logic [W-1:0] eco;
      xa = k[2]; xb = k[1]; xc = k[0];
      test_mode = 1'b1;
      a = {W{xa}}; b = {W{xb}}; cin = xc;
      load_ctrl({L{xc}});
      @(negedge clk);
      chk(sum === {W{xa ^ xb ^ xc}}, "R2 exhaustive sums", {32'd0, sum}, {32'd0, {W{xa ^ xb ^ xc}}});
      chk(cout === mj(xa, xb, xc), "R8 exhaustive cout", {63'd0, cout}, {63'd0, mj(xa, xb, xc)});
      eco = {W{mj(xa, xb, xc)}};
      capture_and_check(eco, "R4 exhaustive carry capture");
    end
  endtask

  task automatic t_pattern();
    for (int n = 0; n < 4; n++) begin
      logic [L-1:0] p;
      logic [W-1:0] eco, es;
      p = L'($urandom());
      test_mode = 1'b1;
      a = $urandom(); b = $urandom(); cin = 1'($urandom());
      load_ctrl(p);
      @(negedge clk);
      es = exp_test_sum(a, b, cin, p);
      eco = exp_test_co(a, b, cin, p);
      chk(sum === es, "R3 bit placement via sums", {32'd0, sum}, {32'd0, es});
      chk(cout === eco[W-1], "R8 pattern cout", {63'd0, cout}, {63'd0, eco[W-1]});
      capture_and_check(eco, "R5 pattern shift-out order");
    end
  endtask

  task automatic t_hold();
    logic [L-1:0] p;
    logic [W-1:0] es;
    p = L'($urandom());
    test_mode = 1'b1; a = $urandom(); b = $urandom(); cin = 1'b1;
    load_ctrl(p);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      scan_in = ~scan_in;
    end
    @(negedge clk);
    es = exp_test_sum(a, b, cin, p);
    chk(sum === es, "R3 control holds without shift enable", {32'd0, sum}, {32'd0, es});
  endtask

  task automatic t_load_prio();
    test_mode = 1'b1; a = '0; b = '0; cin = 1'b0;
    load_ctrl('0);
    @(negedge clk); cap_load = 1'b1;
    @(negedge clk); cap_load = 1'b0;
    a = '1; b = '1;
    @(negedge clk); cap_load = 1'b1; cap_shift = 1'b1;
    @(negedge clk); cap_load = 1'b0; cap_shift = 1'b0;
    chk(scan_out === 1'b1, "R6 load wins over shift", {63'd0, scan_out}, 64'd1);
    @(negedge clk);
    chk(scan_out === 1'b1, "R5 holds with no enables", {63'd0, scan_out}, 64'd1);
    capture_and_check({W{1'b1}}, "R6 all carries after priority load");
  endtask

  task automatic t_normal();
    load_ctrl(L'($urandom()));
    test_mode = 1'b0;
    for (int n = 0; n < 20; n++) begin
      logic [W:0] e;
      @(negedge clk);
      a = $urandom(); b = $urandom(); cin = 1'($urandom());
      if (n == 0) begin a = '1; b = '0; cin = 1'b1; end
      e = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      #1;
      chk({cout, sum} === e, "R1 normal add", {31'd0, cout, sum}, {31'd0, e});
    end
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exhaustive();
    t_pattern();
    t_hold();
    t_load_prio();
    t_normal();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule